// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a chain of 4-bit synchronous up-counter stages. All state changes on the rising clock edge. Each stage can be cleared to zero, loaded in parallel from a data bus, made to count up, or made to hold. Clear wins over load, and load wins over counting. Each stage has two count enables, and it advances only when both are high.

The first enable is shared by all stages. The second enable is passed down the chain: stage 0 takes it from outside, and every later stage takes it from the carry-out flag of the stage below. That carry-out flag is combinational. It is high only while the stage's incoming pass-through enable is high and the stage holds all ones. As a result, the whole chain counts as one wide binary counter.

Because clear is synchronous, logic outside the block can decode a chosen count and pull clear low. The counter then returns to zero on the next edge, which gives a shorter modulus.

Top module: `sync_count_chain`

## Requirements
- R1: With `clr_n` low at a rising edge, `count` becomes all zeros whatever `load_n`, `en_par`, `en_pass` and `din` are.
- R2: With `clr_n` high and `load_n` low at a rising edge, `count` takes the value of `din` whatever the two enables are.
- R3: With `clr_n` and `load_n` both high and both enables high, `count` rises by one at the rising edge.
- R4: With `clr_n` and `load_n` both high and either enable low, `count` keeps its value across the edge.
- R5: Counting from the all-ones value gives all zeros on the next edge (modulo 2^(4·N) wrap).
- R6: `carry_out` is high only while `en_pass` is high and every bit of `count` is one. It follows `en_pass` without waiting for a clock edge, and `en_par` has no effect on it.
- R7: In the chain, stage k (k > 0) advances only on an edge where all lower stages hold all ones, so the `count` bus behaves as one binary counter of 4·N bits. Stage k occupies bits [4k+3:4k].
- R8: If `clr_n` is driven low whenever the low nibble of `count` equals 9, counting cycles through 0..9 and returns to 0 on the edge after 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for every stage |
| clr_n | input | 1 | Active-low synchronous clear, highest priority |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_par | input | 1 | Count enable shared by all stages; does not reach the carry flag |
| en_pass | input | 1 | Count enable of stage 0, passed down the chain through the carry flags |
| din | input | STAGE_W*N_STAGES | Parallel load value |
| count | output | STAGE_W*N_STAGES | Current count; stage k in bits [4k+3:4k] |
| carry_out | output | 1 | Terminal-count flag of the last stage, used to enable a following block |

## Verification
The bench builds the chain with its defaults: two 4-bit stages, which form an 8-bit counter. With two stages, the carry from stage 0 into stage 1 can be seen directly on the ports. The test covers the nibble carry at 0x0F→0x10 and the full wrap at 0xFF→0x00. It also checks that holding `en_pass` low freezes both stages while `en_par` alone never moves the carry flag. A mode in which the bench decodes the count to produce the clear exercises the modulo-10 use. A stretch of randomised control and data is compared every cycle against an 8-bit reference model.

// File: rtl/cnt_chain_pkg.sv
package cnt_chain_pkg;

   typedef enum logic [1:0] {
      OP_CLEAR = 2'd0,
      OP_LOAD  = 2'd1,
      OP_STEP  = 2'd2,
      OP_KEEP  = 2'd3
   } cnt_op_e;

   // priority: clear, then load, then step
   function automatic cnt_op_e pick_op(input logic clr_n,
                                       input logic load_n,
                                       input logic step_ok);
      if (!clr_n)       return OP_CLEAR;
      else if (!load_n) return OP_LOAD;
      else if (step_ok) return OP_STEP;
      else              return OP_KEEP;
   endfunction

endpackage

// File: rtl/cnt_next_sel.sv
module cnt_next_sel
   import cnt_chain_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] ld_val,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic             step_ok,
   output logic [WIDTH-1:0] nxt
);

   cnt_op_e op;

   always_comb begin
      op = pick_op(clr_n, load_n, step_ok);
      unique case (op)
         OP_CLEAR: nxt = '0;
         OP_LOAD:  nxt = ld_val;
         OP_STEP:  nxt = cur + 1'b1;
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic             en_par,
   input  logic             en_pass,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             tc
);

   logic [WIDTH-1:0] q_nxt;
   logic             at_top;

   cnt_next_sel #(.WIDTH(WIDTH)) u_sel (
      .cur     (q),
      .ld_val  (din),
      .clr_n   (clr_n),
      .load_n  (load_n),
      .step_ok (en_par & en_pass),
      .nxt     (q_nxt)
   );

   always_ff @(posedge clk) begin
      q <= q_nxt;
   end

   assign at_top = &q;
   assign tc     = en_pass & at_top;

endmodule

// File: rtl/sync_count_chain.sv
module sync_count_chain #(
   parameter int unsigned STAGE_W  = 4,
   parameter int unsigned N_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          clr_n,
   input  logic                          load_n,
   input  logic                          en_par,
   input  logic                          en_pass,
   input  logic [STAGE_W*N_STAGES-1:0]   din,
   output logic [STAGE_W*N_STAGES-1:0]   count,
   output logic                          carry_out
);

   localparam int unsigned TOT_W = STAGE_W * N_STAGES;

   if (STAGE_W < 1) begin : g_bad_w
      $error("sync_count_chain: STAGE_W must be at least 1");
   end
   if (N_STAGES < 1) begin : g_bad_n
      $error("sync_count_chain: N_STAGES must be at least 1");
   end
   if (TOT_W > 64) begin : g_bad_tot
      $error("sync_count_chain: total width above 64 bits");
   end

   // link[k] is the pass-through enable entering stage k
   logic [N_STAGES:0] link;

   assign link[0] = en_pass;

   for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
      cnt_stage #(.WIDTH(STAGE_W)) u_stage (
         .clk     (clk),
         .clr_n   (clr_n),
         .load_n  (load_n),
         .en_par  (en_par),
         .en_pass (link[k]),
         .din     (din[k*STAGE_W +: STAGE_W]),
         .q       (count[k*STAGE_W +: STAGE_W]),
         .tc      (link[k+1])
      );
   end

   assign carry_out = link[N_STAGES];

endmodule

// File: rtl/sync_count_chain_chk.sv
module sync_count_chain_chk #(
   parameter int unsigned TOT_W = 8
) (
   input logic             clk,
   input logic             clr_n,
   input logic             load_n,
   input logic             en_par,
   input logic             en_pass,
   input logic [TOT_W-1:0] din,
   input logic [TOT_W-1:0] count,
   input logic             carry_out
);

   // state is unknown until the first clear has been seen
   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (!clr_n) armed <= 1'b1;
   end

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed)
      !clr_n |=> count == '0); // R1

   AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!armed)
      clr_n && !load_n |=> count == $past(din)); // R2

   AST_STEP_PLUS_ONE: assert property (@(posedge clk) disable iff (!armed)
      clr_n && load_n && en_par && en_pass |=> count == TOT_W'($past(count) + 1'b1)); // R3

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!armed)
      clr_n && load_n && !(en_par && en_pass) |=> $stable(count)); // R4

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!armed)
      clr_n && load_n && en_par && en_pass && (&count) |=> count == '0); // R5

   AST_CARRY_FLAG: assert property (@(posedge clk) disable iff (!armed)
      carry_out == (en_pass && (&count))); // R6

endmodule

bind sync_count_chain sync_count_chain_chk #(.TOT_W(STAGE_W*N_STAGES)) u_chk (
   .clk       (clk),
   .clr_n     (clr_n),
   .load_n    (load_n),
   .en_par    (en_par),
   .en_pass   (en_pass),
   .din       (din),
   .count     (count),
   .carry_out (carry_out)
);

// File: tb/sync_count_chain_bench.sv
`timescale 1ns/1ps
module sync_count_chain_bench;

   localparam int unsigned SW = 4;
   localparam int unsigned NS = 2;
   localparam int unsigned TW = SW * NS;

   logic          clk = 1'b0;
   logic          clr_drv = 1'b0;
   logic          load_n = 1'b1;
   logic          en_par = 1'b0;
   logic          en_pass = 1'b0;
   logic [TW-1:0] din = '0;
   logic          mod_on = 1'b0;
   logic          clr_n;
   logic [TW-1:0] count;
   logic          carry_out;

   logic [TW-1:0] model = '0;
   int            n_pass = 0;
   int            n_tot = 0;
   int            cycles = 0;
   bit            done = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   // R8: external decode drives clear in modulo mode
   assign clr_n = mod_on ? (count[3:0] != 4'd9) : clr_drv;

   sync_count_chain #(.STAGE_W(SW), .N_STAGES(NS)) u_sync_count_chain (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
      .en_pass(en_pass), .din(din), .count(count), .carry_out(carry_out)
   );

   task automatic chk(input string tag, input string what,
                      input logic [TW-1:0] act, input logic [TW-1:0] exp);
      n_tot++;
      if (act === exp) n_pass++;
      else $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
   endtask

   // called at a falling edge: drive, check flag, step one edge, check count
   task automatic cyc(input string tag, input logic c, input logic l,
                      input logic p, input logic t, input logic [TW-1:0] d);
      logic c_eff;
      clr_drv = c; load_n = l; en_par = p; en_pass = t; din = d;
      #1;
      chk(tag, "carry_out", TW'(carry_out), TW'(t && (model == '1)));
      c_eff = mod_on ? (model[3:0] != 4'd9) : c;
      if (!c_eff)     model = '0;
      else if (!l)    model = d;
      else if (p && t) model = model + 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(tag, "count", count, model);
   endtask

   task automatic t_reset();
      cyc("R1", 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5);
      chk("R1", "count after clear", count, 8'h00);
   endtask

   task automatic t_priority();
      cyc("R2", 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C);   // load with enables low
      cyc("R2", 1'b1, 1'b0, 1'b1, 1'b1, 8'hC3);   // load wins over count
      cyc("R1", 1'b0, 1'b0, 1'b1, 1'b1, 8'h77);   // clear wins over load
   endtask

   task automatic t_count_hold();
      cyc("R2", 1'b1, 1'b0, 1'b0, 1'b0, 8'h20);
      for (int i = 0; i < 3; i++) cyc("R3", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
      cyc("R4", 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF);
      cyc("R4", 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF);
      cyc("R4", 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF);
      chk("R4", "held value", count, 8'h23);
   endtask

   task automatic t_wrap_flag();
      cyc("R2", 1'b1, 1'b0, 1'b0, 1'b0, 8'hFE);
      cyc("R3", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
      cyc("R6", 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);   // en_par low: flag still high
      cyc("R6", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);   // en_pass low: flag low
      cyc("R5", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
      chk("R5", "wrap to zero", count, 8'h00);
   endtask

   task automatic t_cascade();
      cyc("R2", 1'b1, 1'b0, 1'b0, 1'b0, 8'h0E);
      cyc("R7", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
      cyc("R7", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
      chk("R7", "nibble carry", count, 8'h10);
      cyc("R2", 1'b1, 1'b0, 1'b0, 1'b0, 8'h4F);
      cyc("R7", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);   // chain frozen
      chk("R7", "upper frozen", count, 8'h4F);
      cyc("R7", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
      chk("R7", "upper step", count, 8'h50);
   endtask

   task automatic t_mod10();
      cyc("R1", 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
      mod_on = 1'b1;
      for (int i = 0; i < 23; i++) cyc("R8", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
      chk("R8", "mod10 phase", count, 8'h03);
      mod_on = 1'b0;
   endtask

   task automatic t_random();
      for (int i = 0; i < 400; i++) begin
         logic [3:0] r;
         r = 4'($urandom);
         cyc("R3", ($urandom % 16) != 0, ($urandom % 6) != 0,
             r[0] | r[1], r[2] | r[3], TW'($urandom));
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_pass, n_tot);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         n_tot++;
         $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h1F3));
      @(negedge clk);
      t_reset();
      t_priority();
      t_count_hold();
      t_wrap_flag();
      t_cascade();
      t_mod10();
      t_random();
      finish_run();
   end

endmodule